// File: doc/BRIEF.md
# Wait/Hold Timing Bus Controller

This block sits between a CPU-side request port and two target regions, a program-memory window and an I/O window. It decodes each request address to a region and stretches the access by that region's programmed number of wait cycles. It raises a one-cycle completion pulse at the end of the access, and then stays busy for that region's programmed number of hold cycles before it accepts the next request. Addresses that fall in neither window complete at once, with no hold.

Each region has its own timing register that software writes and reads back. Both registers come out of reset at the slowest setting. A request stays valid, with its address stable, until `req_ready` is high on a rising edge. `req_ready` is high only while the controller is idle, so that is the only kind of back-pressure. The timing of an access is captured when the request is accepted, so a register write made during an access only affects later accesses.

Top module: `wait_hold_busctl`

## Requirements
- R1: After reset, both timing registers read 6'h3F (wait 7, hold 7), and `req_ready` is high.
- R2: `cfg_sel`=0 selects the program-memory register and `cfg_sel`=1 selects the I/O register. Bits [2:0] hold the wait count and bits [5:3] hold the hold count. A write with `cfg_we` high is returned on `cfg_rdata` in the next cycle.
- R3: An address in [0x000000, 0x03FFFF] goes to the program region, and `pm_sel` is high during its wait phase. An address in [0xFF0000, 0xFFFFFF] goes to the I/O region, and `io_sel` is high. The two selects are never high together.
- R4: With wait count W, `acc_done` is high in cycle W+1 after the accepting edge.
- R5: With hold count H, `req_ready` stays low after acceptance and goes high again in cycle W+H+2.
- R6: An unmapped address raises neither select and completes with W=0 and H=0: done in cycle 1, ready again in cycle 2.
- R7: A request is accepted only when `req_ready` is high. A request held valid while the controller is busy is accepted at the first edge where `req_ready` is high.
- R8: A timing write made during an access does not change the current access. It applies from the next access.
- R9: `acc_done` pulses exactly once per access, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken this edge |
| req_addr | input | 24 | Request address |
| acc_done | output | 1 | One-cycle completion pulse at end of wait phase |
| pm_sel | output | 1 | Program-region strobe during wait phase |
| io_sel | output | 1 | I/O-region strobe during wait phase |
| cfg_we | input | 1 | Timing register write enable |
| cfg_sel | input | 1 | Register select: 0 program, 1 I/O |
| cfg_wdata | input | 6 | {hold[2:0], wait[2:0]} |
| cfg_rdata | output | 6 | Readback of the selected register |

## Verification
A table of register settings and addresses is walked. It covers wait and hold counts of zero, mid-range values and seven, addresses at both ends of each window, and addresses just outside each window. These cases separate an off-by-one in the wait or hold phase from a decode error at a window edge. A request held valid across a busy period shows whether acceptance is gated to idle. A register write made during a long access shows whether timing is captured at acceptance or read live.

// File: rtl/wh_pkg.sv
package wh_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_PROG = 2'd1,
    RGN_IO   = 2'd2
  } region_e;
endpackage

// File: rtl/wh_decode.sv
module wh_decode
  import wh_pkg::*;
#(
  parameter int AW = 24,
  parameter logic [AW-1:0] PM_BASE = '0,
  parameter int PM_LOG2 = 18,
  parameter logic [AW-1:0] IO_BASE = 24'hFF0000,
  parameter int IO_LOG2 = 16
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);
  localparam logic [AW-PM_LOG2-1:0] PM_TAG = PM_BASE[AW-1:PM_LOG2];
  localparam logic [AW-IO_LOG2-1:0] IO_TAG = IO_BASE[AW-1:IO_LOG2];

  logic hit_pm, hit_io;
  assign hit_pm = (addr[AW-1:PM_LOG2] == PM_TAG);
  assign hit_io = (addr[AW-1:IO_LOG2] == IO_TAG);

  always_comb begin
    if (hit_pm)      region = RGN_PROG;
    else if (hit_io) region = RGN_IO;
    else             region = RGN_NONE;
  end
endmodule

// File: rtl/wh_cfg_regs.sv
module wh_cfg_regs #(
  parameter int CW = 3,
  parameter int NRGN = 2,
  localparam int FW = 2 * CW,
  localparam int SW = (NRGN > 1) ? $clog2(NRGN) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [SW-1:0]            sel,
  input  logic [FW-1:0]            wdata,
  output logic [FW-1:0]            rdata,
  output logic [NRGN-1:0][FW-1:0]  regs
);
  for (genvar g = 0; g < NRGN; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        regs[g] <= '1;
      else if (we && (sel == SW'(g)))    regs[g] <= wdata;
    end
  end

  assign rdata = regs[sel];

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (regs[$past(sel)] == $past(wdata)));
endmodule

// File: rtl/wh_sequencer.sv
module wh_sequencer
  import wh_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  region_e       region_i,
  input  logic [CW-1:0] wait_i,
  input  logic [CW-1:0] hold_i,
  output logic          done,
  output logic          pm_sel,
  output logic          io_sel
);
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_HOLD} state_e;

  state_e        state;
  logic [CW-1:0] cnt, hold_q;
  region_e       rgn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      hold_q <= '0;
      rgn_q  <= RGN_NONE;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state  <= ST_WAIT;
          cnt    <= wait_i;
          hold_q <= hold_i;
          rgn_q  <= region_i;
        end
        ST_WAIT: if (cnt == '0) begin
          state <= (hold_q == '0) ? ST_IDLE : ST_HOLD;
          cnt   <= hold_q;
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_HOLD: if (cnt == CW'(1)) state <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign done      = (state == ST_WAIT) && (cnt == '0);
  assign pm_sel    = (state == ST_WAIT) && (rgn_q == RGN_PROG);
  assign io_sel    = (state == ST_WAIT) && (rgn_q == RGN_IO);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R5
  hold_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> (cnt != '0));
endmodule

// File: rtl/wait_hold_busctl.sv
module wait_hold_busctl
  import wh_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 3,
  parameter logic [AW-1:0] PM_BASE = '0,
  parameter int PM_LOG2 = 18,
  parameter logic [AW-1:0] IO_BASE = 24'hFF0000,
  parameter int IO_LOG2 = 16,
  localparam int FW = 2 * CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          acc_done,
  output logic          pm_sel,
  output logic          io_sel,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [FW-1:0] cfg_wdata,
  output logic [FW-1:0] cfg_rdata
);
  localparam int NRGN = 2;

  region_e                 region;
  logic [NRGN-1:0][FW-1:0] regs;
  logic [CW-1:0]           wait_sel, hold_sel;

  wh_decode #(.AW(AW), .PM_BASE(PM_BASE), .PM_LOG2(PM_LOG2),
              .IO_BASE(IO_BASE), .IO_LOG2(IO_LOG2)) u_dec (
    .addr(req_addr), .region(region));

  wh_cfg_regs #(.CW(CW), .NRGN(NRGN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .regs(regs));

  always_comb begin
    case (region)
      RGN_PROG: begin wait_sel = regs[0][CW-1:0]; hold_sel = regs[0][FW-1:CW]; end
      RGN_IO:   begin wait_sel = regs[1][CW-1:0]; hold_sel = regs[1][FW-1:CW]; end
      default:  begin wait_sel = '0;              hold_sel = '0;              end
    endcase
  end

  wh_sequencer #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .region_i(region), .wait_i(wait_sel), .hold_i(hold_sel),
    .done(acc_done), .pm_sel(pm_sel), .io_sel(io_sel));

  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pm_sel, io_sel}));
  // R6
  unmapped_nohold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_done && !pm_sel && !io_sel) |=> req_ready);
endmodule

// File: tb/sim_wait_hold_busctl.sv
module sim_wait_hold_busctl;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, cfg_we = 0, cfg_sel = 0;
  logic [23:0] req_addr = '0;
  logic [5:0]  cfg_wdata = '0;
  logic        req_ready, acc_done, pm_sel, io_sel;
  logic [5:0]  cfg_rdata;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  wait_hold_busctl u0 (.*);

  typedef struct packed {
    logic sel; logic [5:0] val; logic [23:0] addr;
    logic [2:0] w; logic [2:0] h; logic [1:0] rgn;
  } vec_t;
  localparam vec_t VEC [7] = '{
    '{1'b0, 6'h13, 24'h000100, 3'd3, 3'd2, 2'd1},
    '{1'b1, 6'h01, 24'hFF0010, 3'd1, 3'd0, 2'd2},
    '{1'b0, 6'h00, 24'h03FFFF, 3'd0, 3'd0, 2'd1},
    '{1'b1, 6'h38, 24'hFFFFFF, 3'd0, 3'd7, 2'd2},
    '{1'b0, 6'h2E, 24'h040000, 3'd0, 3'd0, 2'd0},
    '{1'b1, 6'h0A, 24'hFEFFFF, 3'd0, 3'd0, 2'd0},
    '{1'b0, 6'h2E, 24'h000000, 3'd6, 3'd5, 2'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic s, input logic [5:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
    chk(cfg_rdata == v, "R2 readback", cfg_rdata, v);
  endtask

  task automatic do_access(input logic [23:0] a, input int w, input int h,
                           input logic [1:0] rgn, input bit mw, input logic [5:0] mval);
    int k = 0, dcnt = 0, dk = 0, rk = 0;
    logic [1:0] sel = 2'b00;
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 idle ready", req_ready, 1);
    req_valid = 1; req_addr = a;
    while (rk == 0 && k < 40) begin
      @(negedge clk); k++;
      if (acc_done) begin dcnt++; dk = k; sel = {io_sel, pm_sel}; end
      if (req_ready) rk = k;
      req_valid = 0; cfg_we = 0;
      if (mw && k == 2) begin cfg_we = 1; cfg_sel = 0; cfg_wdata = mval; end
    end
    cfg_we = 0;
    chk(dcnt == 1, "R9 one done pulse", dcnt, 1);
    chk(dk == w + 1, "R4 done cycle", dk, w + 1);
    chk(rk == w + h + 2, "R5 ready return", rk, w + h + 2);
    chk(sel == rgn, (rgn == 0) ? "R6 no select" : "R3 region select", sel, rgn);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    cfg_sel = 0; #0.1;
    chk(cfg_rdata == 6'h3F, "R1 program reg reset", cfg_rdata, 6'h3F);
    cfg_sel = 1; #0.1;
    chk(cfg_rdata == 6'h3F, "R1 io reg reset", cfg_rdata, 6'h3F);
    do_access(24'hFF0004, 7, 7, 2'd2, 0, 6'h00);

    for (int i = 0; i < 7; i++) begin
      wr_cfg(VEC[i].sel, VEC[i].val);
      do_access(VEC[i].addr, VEC[i].w, VEC[i].h, VEC[i].rgn, 0, 6'h00);
    end

    // R8 write during access applies next time
    wr_cfg(1'b0, 6'h3F);
    do_access(24'h000200, 7, 7, 2'd1, 1, 6'h00);
    do_access(24'h000200, 0, 0, 2'd1, 0, 6'h00);

    // R7 request held while busy: program W=1 H=2, then unmapped
    wr_cfg(1'b0, 6'h11);
    begin
      int k = 0, d1 = 0, d2 = 0, dc = 0;
      @(negedge clk);
      req_valid = 1; req_addr = 24'h000010;
      @(negedge clk); req_addr = 24'h800000;
      for (int j = 0; j < 10; j++) begin
        if (j > 0) @(negedge clk);
        k++;
        if (acc_done) begin dc++; if (dc == 1) d1 = k; else d2 = k; end
        if (k == 6) req_valid = 0;
      end
      chk(dc == 2, "R7 two accesses", dc, 2);
      chk(d1 == 2, "R7 first done", d1, 2);
      chk(d2 == 6, "R7 held request accepted on ready", d2, 6);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule